// File: doc/BRIEF.md
# LFSR-Sequenced Accumulator Processor

A very small 16-bit accumulator processor whose program counter has no incrementer. After each instruction the 8-bit program counter takes one step of a maximal-length linear feedback shift register, so a program occupies the addresses in LFSR order rather than in linear order. The datapath has no adder. It has only XOR, AND, single-bit shifts, load, store and two jumps.

Each instruction is fetched from a synchronous word memory with one cycle of read latency. When the instruction's indirect flag is set, a second read brings in a 16-bit operand. The instruction then executes, with at most one data access. Any load or store whose effective address has its top bit set goes to a byte-wide I/O port and not to memory. The all-zero counter state cannot advance, so after reset the core repeats the word at address 0 until that word jumps somewhere else.

Top module: `lfsr_acc_cpu`

## Requirements
- R1: While reset is held, `mem_we_o`, `out_valid_o` and `in_ack_o` are low and the core requests a read of address 0. The first instruction after reset comes from address 0.
- R2: While the program counter is 0, any instruction other than a taken jump leaves it at 0, so the word at address 0 is executed again and again.
- R3: After any instruction that does not jump, the program counter shifts left by one bit. The new bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). Starting from 1, it visits all 255 nonzero states before it returns to 1.
- R4: Opcode 6 loads the program counter with ARG[7:0]. Opcode 7 does the same only when the accumulator is zero, and otherwise it advances as in R3.
- R5: An instruction word holds the indirect flag in bit 15, the opcode in bits 14:12 and the operand in bits 11:0. With the flag clear, ARG is the operand zero-extended to 16 bits. Opcode 0 sets ACC to ACC^ARG and opcode 1 sets ACC to ACC&ARG.
- R6: Opcode 2 sets ACC to ARG<<1 and opcode 3 sets ACC to ARG>>1 (logical). Neither depends on the previous ACC.
- R7: With the indirect flag set, ARG is the 16-bit word read from memory at the 12-bit operand. This holds for every opcode, including load and store.
- R8: With ARG[15] clear, opcode 4 sets ACC to MEM[ARG] and opcode 5 writes ACC to MEM[ARG].
- R9: A store with ARG[15] set raises `out_valid_o` for exactly one cycle with `out_data_o` equal to ACC[7:0]. It writes no memory.
- R10: A load with ARG[15] set gives ACC the zero-extended input byte and pulses `in_ack_o` for one cycle when `in_valid_i` is high. When `in_valid_i` is low it gives ACC all ones and there is no acknowledge.
- R11: Fetches of direct, non-load instructions come 3 cycles apart. An indirect operand adds one cycle and a memory load adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory access request this cycle |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data (accumulator) |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte available |
| in_ack_o | output | 1 | Input byte consumed |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte strobe |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request, and that `in_valid_i` stays steady while an I/O load executes, so that an acknowledge always comes with a valid byte. The stimulus meets both conditions. The bench's memory model answers every request at the next clock edge, and the input port is held constant for the whole of each program run. The sweeps build each program along the LFSR address chain. They read results back through ordinary stores, so all checks of accumulator values go through the memory and I/O ports only.

// File: rtl/lfsr_acc_pkg.sv
package lfsr_acc_pkg;

  typedef enum logic [2:0] {
    OP_XOR = 3'd0,
    OP_AND = 3'd1,
    OP_SHL = 3'd2,
    OP_SHR = 3'd3,
    OP_LD  = 3'd4,
    OP_ST  = 3'd5,
    OP_JMP = 3'd6,
    OP_JZ  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_EXEC,
    ST_LDWB
  } state_e;

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  // Fibonacci XOR form: zero maps to zero (lock-up state)
  assign nxt_o = {cur_i[W-2:0], ^(cur_i & TAPS)};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import lfsr_acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_XOR:  res_o = acc_i ^ arg_i;
      OP_AND:  res_o = acc_i & arg_i;
      OP_SHL:  res_o = arg_i << 1;
      OP_SHR:  res_o = arg_i >> 1;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/lfsr_acc_cpu.sv
module lfsr_acc_cpu
  import lfsr_acc_pkg::*;
#(
  parameter int                DATA_W  = 16,
  parameter int                OPND_W  = 12,
  parameter int                PC_W    = 8,
  parameter logic [PC_W-1:0]   PC_TAPS = 8'hB8,
  parameter int                IO_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [IO_W-1:0]   in_data_i,
  input  logic              in_valid_i,
  output logic              in_ack_o,
  output logic [IO_W-1:0]   out_data_o,
  output logic              out_valid_o
);
  localparam int IND_BIT = DATA_W - 1;
  localparam int IO_BIT  = DATA_W - 1;
  localparam int OP_LSB  = OPND_W;
  localparam int EXT_W   = DATA_W - OPND_W;
  localparam int PC_PAD  = DATA_W - PC_W;
  localparam int IO_PAD  = DATA_W - IO_W;

  state_e            st_q;
  op_e               op_q;
  logic [PC_W-1:0]   pc_q, pc_nxt;
  logic [DATA_W-1:0] acc_q, arg_q, alu_res;
  logic              take, is_io;

  lfsr_step #(.W(PC_W), .TAPS(PC_TAPS)) u_step (
    .cur_i (pc_q),
    .nxt_o (pc_nxt)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_q),
    .acc_i (acc_q),
    .arg_i (arg_q),
    .res_o (alu_res)
  );

  assign take  = (op_q == OP_JMP) || ((op_q == OP_JZ) && (acc_q == '0));
  assign is_io = arg_q[IO_BIT];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = acc_q;
    unique case (st_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {{PC_PAD{1'b0}}, pc_q};
      end
      ST_DECODE: if (mem_rdata_i[IND_BIT]) begin
        mem_req_o  = 1'b1;
        mem_addr_o = {{EXT_W{1'b0}}, mem_rdata_i[OPND_W-1:0]};
      end
      ST_EXEC: if (!is_io && (op_q == OP_LD || op_q == OP_ST)) begin
        mem_req_o  = 1'b1;
        mem_we_o   = (op_q == OP_ST);
        mem_addr_o = arg_q;
      end
      default: ;
    endcase
  end

  assign out_valid_o = (st_q == ST_EXEC) && (op_q == OP_ST) && is_io;
  assign out_data_o  = acc_q[IO_W-1:0];
  assign in_ack_o    = (st_q == ST_EXEC) && (op_q == OP_LD) && is_io && in_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      op_q  <= OP_XOR;
      pc_q  <= '0;
      acc_q <= '0;
      arg_q <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: st_q <= ST_DECODE;
        ST_DECODE: begin
          op_q  <= op_e'(mem_rdata_i[OP_LSB +: 3]);
          arg_q <= {{EXT_W{1'b0}}, mem_rdata_i[OPND_W-1:0]};
          st_q  <= mem_rdata_i[IND_BIT] ? ST_OPND : ST_EXEC;
        end
        ST_OPND: begin
          arg_q <= mem_rdata_i;
          st_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q <= take ? arg_q[PC_W-1:0] : pc_nxt;
          unique case (op_q)
            OP_XOR, OP_AND, OP_SHL, OP_SHR: acc_q <= alu_res;
            OP_LD: if (is_io)
              acc_q <= in_valid_i ? {{IO_PAD{1'b0}}, in_data_i} : '1;
            default: ;
          endcase
          st_q <= (op_q == OP_LD && !is_io) ? ST_LDWB : ST_FETCH;
        end
        ST_LDWB: begin
          acc_q <= mem_rdata_i;
          st_q  <= ST_FETCH;
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/lfsr_acc_cpu_chk.sv
module lfsr_acc_cpu_chk
  import lfsr_acc_pkg::*;
#(
  parameter int              DATA_W  = 16,
  parameter int              PC_W    = 8,
  parameter logic [PC_W-1:0] PC_TAPS = 8'hB8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input state_e            st,
  input op_e               op,
  input logic [PC_W-1:0]   pc,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] arg,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic              in_valid_i,
  input logic              in_ack_o,
  input logic              out_valid_o
);
  function automatic logic [PC_W-1:0] step(logic [PC_W-1:0] p);
    logic fb = 1'b0;
    for (int i = 0; i < PC_W; i++) if (PC_TAPS[i]) fb ^= p[i];
    return {p[PC_W-2:0], fb};
  endfunction

  logic jumping;
  assign jumping = (op == OP_JMP) || (op == OP_JZ && acc == '0);

  // R2
  pc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && pc == '0 && !jumping) |=> (pc == '0));

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && !jumping) |=> (pc == step($past(pc))));

  // R4
  jump_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_EXEC && jumping) |=> (pc == $past(arg[PC_W-1:0])));

  // R9
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R9
  io_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[DATA_W-1]);

  // R10
  ack_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> in_valid_i);

  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |=> !in_ack_o);
endmodule

bind lfsr_acc_cpu lfsr_acc_cpu_chk #(
  .DATA_W (DATA_W),
  .PC_W   (PC_W),
  .PC_TAPS(PC_TAPS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st          (st_q),
  .op          (op_q),
  .pc          (pc_q),
  .acc         (acc_q),
  .arg         (arg_q),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .in_valid_i  (in_valid_i),
  .in_ack_o    (in_ack_o),
  .out_valid_o (out_valid_o)
);

// File: tb/sim_lfsr_acc_cpu.sv
`timescale 1ns/1ps
module sim_lfsr_acc_cpu;
  localparam int XOR_ = 0, AND_ = 1, SHL_ = 2, SHR_ = 3, LD_ = 4, ST_ = 5, JMP_ = 6, JZ_ = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  in_data, out_data;
  logic        in_valid, in_ack, out_valid;

  always #2.5 clk = ~clk;

  lfsr_acc_cpu u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ack_o(in_ack),
    .out_data_o(out_data), .out_valid_o(out_valid)
  );

  logic [15:0] mem [0:1023];
  logic [7:0]  fadr [0:299];
  int          ftime [0:299];
  int          nf, n_out, n_ack, n_badwe, cyc;
  logic [7:0]  last_out;
  int          total = 0, bad = 0;
  logic [7:0]  cur;

  initial begin cyc = 0; nf = 0; n_out = 0; n_ack = 0; n_badwe = 0; mem_rdata = '0; end

  // synchronous memory model with one-cycle read latency, plus monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_req) begin
        if (mem_we) begin
          if (mem_addr[15]) n_badwe <= n_badwe + 1;
          else mem[mem_addr[9:0]] <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[9:0]];
          if (nf < 300) begin
            fadr[nf]  <= mem_addr[7:0];
            ftime[nf] <= cyc;
            nf        <= nf + 1;
          end
        end
      end
      if (out_valid) begin n_out <= n_out + 1; last_out <= out_data; end
      if (in_ack) n_ack <= n_ack + 1;
    end
  end

  function automatic logic [7:0] nx(logic [7:0] p);
    return {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
  endfunction

  function automatic logic [15:0] enc(logic ind, int op, logic [11:0] v);
    logic [2:0] o = op[2:0];
    return {ind, o, v};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic emit(logic [15:0] w);
    mem[{2'b00, cur}] = w;
    cur = nx(cur);
  endtask

  task automatic start_prog();
    clear();
    mem[0] = enc(1'b0, JMP_, 12'h001);
    cur = 8'h01;
  endtask

  task automatic halt();
    emit(enc(1'b0, JMP_, {4'h0, cur}));
  endtask

  task automatic run(int n, logic iv, logic [7:0] id);
    @(negedge clk);
    in_valid = iv; in_data = id; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    nf = 0; n_out = 0; n_ack = 0; n_badwe = 0;
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] model(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      XOR_:    return a ^ b;
      AND_:    return a & b;
      SHL_:    return b << 1;
      default: return b >> 1;
    endcase
  endfunction

  task automatic sweep_one(int op, logic [15:0] a, logic [15:0] b, logic ind);
    logic [15:0] argv;
    start_prog();
    mem[10'h300] = a;
    mem[10'h301] = b;
    emit(enc(1'b0, LD_, 12'h300));
    if (ind) begin emit(enc(1'b1, op, 12'h301)); argv = b; end
    else begin emit(enc(1'b0, op, b[11:0])); argv = {4'h0, b[11:0]}; end
    emit(enc(1'b0, ST_, 12'h310));
    halt();
    run(30, 1'b0, 8'h00);
    if (op <= AND_) chk(ind ? "R5/R7 logic op indirect" : "R5 logic op immediate",
                        mem[10'h310], model(op, a, argv));
    else chk(ind ? "R6/R7 shift indirect" : "R6 shift immediate",
             mem[10'h310], model(op, a, argv));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] pats [0:7];
    int errs;
    logic [7:0] p;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;
    pats[4] = 16'h8001; pats[5] = 16'h1234; pats[6] = 16'hF00F; pats[7] = 16'h7FFE;
    in_valid = 1'b0; in_data = '0;
    clear();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mem_we in reset", mem_we, 1'b0);
    chk("R1 out_valid in reset", out_valid, 1'b0);
    chk("R1 in_ack in reset", in_ack, 1'b0);
    chk("R1 fetch addr in reset", {mem_req, mem_addr}, {1'b1, 16'h0000});

    // R2: lock at address 0
    clear();
    mem[0] = enc(1'b0, XOR_, 12'h001);
    run(60, 1'b0, 8'h00);
    errs = 0;
    for (int k = 0; k < nf; k++) if (fadr[k] != 8'h00) errs++;
    chk("R2 fetch count at 0", nf >= 15, 1'b1);
    chk("R2 all fetches at 0", errs, 0);
    chk("R1 first fetch address", fadr[0], 8'h00);

    // R3 / R11: full LFSR walk, 3-cycle spacing
    clear();
    mem[0] = enc(1'b0, JMP_, 12'h001);
    for (int i = 1; i < 256; i++) mem[i] = enc(1'b0, AND_, 12'hFFF);
    run(900, 1'b0, 8'h00);
    errs = 0;
    p = 8'h01;
    for (int k = 1; k <= 256; k++) begin
      if (fadr[k] != p) errs++;
      p = nx(p);
    end
    chk("R3 LFSR fetch order", errs, 0);
    chk("R3 period returns to 1", fadr[256], 8'h01);
    errs = 0;
    for (int k = 1; k < 256; k++) if (ftime[k+1] - ftime[k] != 3) errs++;
    chk("R11 direct instr spacing", errs, 0);

    // R4: JUMPZ taken / not taken, JUMP uses ARG[7:0]
    for (int z = 0; z < 3; z++) begin
      start_prog();
      mem[10'h300] = (z == 1) ? 16'h0042 : 16'h0000;
      mem[10'h302] = 16'h0111;
      mem[10'h303] = 16'h0222;
      emit(enc(1'b0, LD_, 12'h300));
      if (z == 2) emit(enc(1'b0, JMP_, 12'h1C0));
      else emit(enc(1'b0, JZ_, 12'h0C0));
      emit(enc(1'b0, LD_, 12'h302));
      emit(enc(1'b0, ST_, 12'h310));
      halt();
      cur = 8'hC0;
      emit(enc(1'b0, LD_, 12'h303));
      emit(enc(1'b0, ST_, 12'h310));
      halt();
      run(50, 1'b0, 8'h00);
      chk(z == 0 ? "R4 jumpz taken" : (z == 1 ? "R4 jumpz not taken" : "R4 jump low bits"),
          mem[10'h310], (z == 1) ? 16'h0111 : 16'h0222);
    end

    // R5 / R6 / R7: sweeps over operand patterns
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int ind = 0; ind < 2; ind++)
            sweep_one(op, pats[i], pats[j], ind[0]);
    for (int op = 2; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int ind = 0; ind < 2; ind++)
          sweep_one(op, pats[(i + 3) % 8], pats[i], ind[0]);

    // R7 / R8: indirect load and indirect store addresses
    start_prog();
    mem[10'h301] = 16'hBEEF;
    mem[10'h305] = 16'h0320;
    mem[10'h306] = 16'h0301;
    emit(enc(1'b1, LD_, 12'h306));
    emit(enc(1'b1, ST_, 12'h305));
    halt();
    run(40, 1'b0, 8'h00);
    chk("R7/R8 indirect load+store", mem[10'h320], 16'hBEEF);
    chk("R8 pointer cell untouched", mem[10'h305], 16'h0320);

    // R11: load with indirect operand takes 3+1+1 cycles
    chk("R11 load+indirect spacing", ftime[4] - ftime[1], 5);

    // R9 / R10: I/O load and store
    for (int v = 0; v < 2; v++) begin
      start_prog();
      mem[10'h304] = (v == 1) ? 16'h8000 : 16'hFFF0;
      emit(enc(1'b1, LD_, 12'h304));
      emit(enc(1'b0, ST_, 12'h310));
      emit(enc(1'b1, ST_, 12'h304));
      halt();
      run(50, v[0], 8'hA5);
      chk("R10 io load value", mem[10'h310], (v == 1) ? 16'h00A5 : 16'hFFFF);
      chk("R10 ack count", n_ack, (v == 1) ? 1 : 0);
      chk("R9 out strobe count", n_out, 1);
      chk("R9 out byte", last_out, (v == 1) ? 8'hA5 : 8'hFF);
      chk("R9 no memory write to io", n_badwe, 0);
      chk("R9 cell 0 untouched", mem[0], enc(1'b0, JMP_, 12'h001));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule